// File: doc/BRIEF.md
# Single-Instruction Counter Interrupt Unit

This unit services counter interrupt levels without a full context switch. Each level has a dedicated location in memory. That location holds one counter operation word, which gives the operand size, a signed modifier and the effective byte address of the counter. When a level is requested, the unit holds the running program. It then fetches the operation word, reads the counter word and adds the sign-extended modifier within the operand width. It writes the sum back to the same location, then clears and re-arms the level and releases the program. Processor status flags are never touched, and an overflow simply wraps.

One level can be mapped. While mapping is enabled, that level's counter address is relocated by a fixed page offset, and every other level always uses the physical address. No protection check is applied to any of these accesses. On count-pulse levels, a sum of exactly zero produces a one-cycle counter-equals-zero event that names the level. That event can feed a second interrupt.

Top module: `cnt_irq_unit`

## Requirements
- R1: After reset, the unit issues no memory read or write, and `prog_hold`, `clr_arm` and `zero_evt` are all low.
- R2: A single-cycle pulse on `lvl_req[n]` into an idle unit produces a one-hot `clr_arm` pulse for level n in the 7th cycle after the request cycle. `prog_hold` stays high from the cycle after pending capture until that pulse. During that span the unit makes exactly two reads and then one write.
- R3: The operation word of level n is read from word address `LOC_BASE/4 + n`. Its fields are as follows: bits [31:30] give the size (00 byte, 01 halfword, 10 and 11 word), bits [23:16] hold the signed modifier, and bits [15:0] hold the effective byte address. Bits [29:24] are ignored.
- R4: The sum is formed modulo 2^8, 2^16 or 2^32 for byte, halfword or word. It is written little-endian only into its own lane: the byte lane is address bits [1:0], the halfword lane is address bit [1], and a word ignores address bits [1:0]. All other bytes of the word keep their values.
- R5: The counter address is physical for every level. The one exception is level `MAP_LVL` while `map_en` is high, which uses the effective address plus `MAP_OFS`.
- R6: For a level whose bit is set in `CP_MASK`, a sum of zero raises `zero_evt` for one cycle with `zero_lvl` equal to the level. This happens in the cycle after the write-back, together with `clr_arm`. No event is raised for a nonzero sum or for other levels.
- R7: When several levels are pending, the lowest-numbered level is served first.
- R8: A new request for a level while that level is being served is held pending. It is served as a full second operation after the `clr_arm` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req | input | NLVL | Activation pulse per level |
| map_en | input | 1 | Mapping enable for the mapped level |
| prog_hold | output | 1 | Program suspended while high |
| act_lvl | output | $clog2(NLVL) | Level in service |
| clr_arm | output | NLVL | One-cycle clear-and-arm pulse, one-hot |
| zero_evt | output | 1 | Counter-equals-zero event pulse |
| zero_lvl | output | $clog2(NLVL) | Level that raised the zero event |
| mem_rd | output | 1 | Memory read strobe; data is returned the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables, bit i for bits [8i+7:8i] |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |

## Verification
A wrong lane shift or width mask shows up as corrupted neighbour bytes or a missing wrap in the counter word. This is visible right after the `clr_arm` pulse for that service. A stuck pending bit or a bad priority choice shows up as a `clr_arm` pulse with the wrong level or at the wrong cycle. It is seen within 7 to 14 cycles of the request. A wrong zero test or a wrong count-pulse decode shows up as a missing or spurious `zero_evt` in the same cycle as `clr_arm`.

// File: rtl/cnt_irq_pkg.sv
package cnt_irq_pkg;

  localparam int DW = 32;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORDX = 2'b11
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPRD, ST_OPWT, ST_DRD, ST_DWT, ST_WR, ST_DONE
  } svc_st_e;

  // bit offset of the operand lane inside the word
  function automatic logic [4:0] f_shift(input size_e sz, input logic [1:0] a);
    case (sz)
      SZ_BYTE: f_shift = {a, 3'b000};
      SZ_HALF: f_shift = {a[1], 4'b0000};
      default: f_shift = 5'd0;
    endcase
  endfunction

  function automatic logic [DW-1:0] f_mask(input size_e sz);
    case (sz)
      SZ_BYTE: f_mask = 32'h0000_00FF;
      SZ_HALF: f_mask = 32'h0000_FFFF;
      default: f_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [3:0] f_be(input size_e sz, input logic [1:0] a);
    case (sz)
      SZ_BYTE: f_be = 4'b0001 << a;
      SZ_HALF: f_be = a[1] ? 4'b1100 : 4'b0011;
      default: f_be = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/cnt_irq_arb.sv
module cnt_irq_arb #(
  parameter int NLVL = 8,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_i,
  input  logic            take_i,
  output logic [NLVL-1:0] pend_o,
  output logic [NLVL-1:0] grant_o,
  output logic [LW-1:0]   gidx_o,
  output logic            any_o
);
  logic [NLVL-1:0] pend_q;

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    gidx_o  = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (pend_q[i] && !found) begin
        found      = 1'b1;
        grant_o[i] = 1'b1;
        gidx_o     = LW'(i);
      end
    end
  end

  assign any_o  = |pend_q;
  assign pend_o = pend_q;

  // new requests win over the clear so a re-request is never lost
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~(take_i ? grant_o : '0)) | req_i;

  // R7
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && ((grant_o & ~pend_q) == '0));
  // R8
  pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_i & pend_q)) |=> (|(pend_q & $past(req_i))));
endmodule

// File: rtl/cnt_irq_addr.sv
module cnt_irq_addr #(
  parameter int          NLVL     = 8,
  parameter int          AW       = 16,
  parameter logic [15:0] LOC_BASE = 16'h0040,
  parameter int          MAP_LVL  = 4,
  parameter logic [15:0] MAP_OFS  = 16'h0100,
  localparam int LW  = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int WAW = AW - 2
) (
  input  logic [LW-1:0]  lvl_i,
  input  logic [AW-1:0]  ea_i,
  input  logic           map_en_i,
  output logic [WAW-1:0] loc_waddr_o,
  output logic [WAW-1:0] opd_waddr_o,
  output logic           mapped_o
);
  localparam logic [AW-1:0] BASE_B = AW'(LOC_BASE);
  localparam logic [AW-1:0] OFS_B  = AW'(MAP_OFS);

  logic [AW-1:0] opd_b;

  assign loc_waddr_o = BASE_B[AW-1:2] + WAW'(lvl_i);
  assign mapped_o    = map_en_i && (lvl_i == LW'(MAP_LVL));
  assign opd_b       = mapped_o ? (ea_i + OFS_B) : ea_i;
  assign opd_waddr_o = opd_b[AW-1:2];
endmodule

// File: rtl/cnt_irq_alu.sv
module cnt_irq_alu
  import cnt_irq_pkg::*;
#(
  parameter int MOD_W = 8
) (
  input  size_e          size_i,
  input  logic [1:0]     alo_i,
  input  logic [MOD_W-1:0] mod_i,
  input  logic [DW-1:0]  rdata_i,
  output logic [DW-1:0]  wdata_o,
  output logic [3:0]     be_o,
  output logic           zero_o
);
  logic [4:0]    sh;
  logic [DW-1:0] lane, mask, sext, sum;

  assign sh      = f_shift(size_i, alo_i);
  assign mask    = f_mask(size_i);
  assign sext    = {{(DW-MOD_W){mod_i[MOD_W-1]}}, mod_i};
  assign lane    = (rdata_i >> sh) & mask;
  assign sum     = (lane + sext) & mask;
  assign wdata_o = sum << sh;
  assign be_o    = f_be(size_i, alo_i);
  assign zero_o  = (sum == '0);

  // R4
  lane_be_chk: assert final ((size_i != SZ_BYTE) || ($countones(be_o) == 1));
endmodule

// File: rtl/cnt_irq_unit.sv
module cnt_irq_unit
  import cnt_irq_pkg::*;
#(
  parameter int          NLVL     = 8,
  parameter int          AW       = 16,
  parameter int          MOD_W    = 8,
  parameter logic [15:0] LOC_BASE = 16'h0040,
  parameter int          MAP_LVL  = 4,
  parameter logic [15:0] MAP_OFS  = 16'h0100,
  parameter logic [7:0]  CP_MASK  = 8'hF0,
  localparam int LW  = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int WAW = AW - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] lvl_req,
  input  logic            map_en,
  output logic            prog_hold,
  output logic [LW-1:0]   act_lvl,
  output logic [NLVL-1:0] clr_arm,
  output logic            zero_evt,
  output logic [LW-1:0]   zero_lvl,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [WAW-1:0]  mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [3:0]      mem_be,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int MOD_LO = AW;
  localparam int MOD_HI = AW + MOD_W - 1;

  svc_st_e        st;
  logic [LW-1:0]  lvl_q;
  logic [DW-1:0]  op_q, wdata_q;
  logic [3:0]     be_q;
  logic           zero_q;
  logic [WAW-1:0] waddr_q;

  // named internal events
  logic            take;
  logic [NLVL-1:0] pend, grant;
  logic [LW-1:0]   gidx;
  logic            any_pend;
  logic [WAW-1:0]  loc_waddr, opd_waddr;
  logic            mapped;
  size_e           op_size;
  logic [DW-1:0]   alu_wdata;
  logic [3:0]      alu_be;
  logic            alu_zero;
  logic            cp_lvl;

  assign op_size = size_e'(op_q[31:30]);
  assign take    = (st == ST_IDLE) && any_pend;
  assign cp_lvl  = CP_MASK[lvl_q];

  cnt_irq_arb #(.NLVL(NLVL)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(lvl_req), .take_i(take),
    .pend_o(pend), .grant_o(grant), .gidx_o(gidx), .any_o(any_pend)
  );

  cnt_irq_addr #(
    .NLVL(NLVL), .AW(AW), .LOC_BASE(LOC_BASE), .MAP_LVL(MAP_LVL), .MAP_OFS(MAP_OFS)
  ) u_addr (
    .lvl_i(lvl_q), .ea_i(op_q[AW-1:0]), .map_en_i(map_en),
    .loc_waddr_o(loc_waddr), .opd_waddr_o(opd_waddr), .mapped_o(mapped)
  );

  cnt_irq_alu #(.MOD_W(MOD_W)) u_alu (
    .size_i(op_size), .alo_i(op_q[1:0]), .mod_i(op_q[MOD_HI:MOD_LO]),
    .rdata_i(mem_rdata), .wdata_o(alu_wdata), .be_o(alu_be), .zero_o(alu_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lvl_q   <= '0;
      op_q    <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      zero_q  <= 1'b0;
      waddr_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (any_pend) begin
          lvl_q <= gidx;
          st    <= ST_OPRD;
        end
        ST_OPRD: st <= ST_OPWT;
        ST_OPWT: begin
          op_q <= mem_rdata;
          st   <= ST_DRD;
        end
        ST_DRD: begin
          waddr_q <= opd_waddr;
          st      <= ST_DWT;
        end
        ST_DWT: begin
          wdata_q <= alu_wdata;
          be_q    <= alu_be;
          zero_q  <= alu_zero;
          st      <= ST_WR;
        end
        ST_WR:   st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    mem_addr = '0;
    case (st)
      ST_OPRD: begin mem_rd = 1'b1; mem_addr = loc_waddr; end
      ST_DRD:  begin mem_rd = 1'b1; mem_addr = opd_waddr; end
      ST_WR:   begin mem_wr = 1'b1; mem_addr = waddr_q;   end
      default: ;
    endcase
  end

  assign mem_wdata = wdata_q;
  assign mem_be    = mem_wr ? be_q : 4'b0000;
  assign prog_hold = (st != ST_IDLE);
  assign act_lvl   = lvl_q;
  assign clr_arm   = (st == ST_DONE) ? (NLVL'(1) << lvl_q) : '0;
  assign zero_evt  = (st == ST_DONE) && zero_q && cp_lvl;
  assign zero_lvl  = lvl_q;

  // R2
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R2
  clr_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_arm) |-> ($onehot(clr_arm) && $past(mem_wr)));
  // R2
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_hold) |-> $past(|clr_arm));
  // R6
  zero_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> ($past(mem_wr) && (|clr_arm)));
  // R4
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && op_size == SZ_BYTE) |-> ($countones(mem_be) == 1));
endmodule

// File: tb/tb_cnt_irq_unit.sv
module tb_cnt_irq_unit;
  localparam int PER = 10;
  localparam int NLVL = 8;
  localparam logic [15:0] LOCB = 16'h0040;
  localparam logic [15:0] MOFS = 16'h0100;
  localparam logic [7:0]  CPM  = 8'hF0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NLVL-1:0] lvl_req = '0;
  logic map_en = 1'b0;
  logic prog_hold, zero_evt, mem_rd, mem_wr;
  logic [2:0] act_lvl, zero_lvl;
  logic [NLVL-1:0] clr_arm;
  logic [13:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  logic [31:0] mem [0:255];
  int vecs = 0, bad = 0;

  always #(PER/2) clk = ~clk;

  cnt_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .map_en(map_en),
    .prog_hold(prog_hold), .act_lvl(act_lvl), .clr_arm(clr_arm),
    .zero_evt(zero_evt), .zero_lvl(zero_lvl), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // lane geometry restated as a byte count and a first byte
  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction
  function automatic int first_b(input logic [1:0] sz, input logic [15:0] ea);
    return (sz == 2'b00) ? int'(ea[1:0]) : (sz == 2'b01) ? (ea[1] ? 2 : 0) : 0;
  endfunction
  function automatic logic [31:0] get_lane(input logic [31:0] w, input logic [1:0] sz, input logic [15:0] ea);
    logic [31:0] v = '0;
    for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = w[8*(first_b(sz, ea)+k) +: 8];
    return v;
  endfunction
  function automatic logic [31:0] put_lane(input logic [31:0] w, input logic [1:0] sz, input logic [15:0] ea, input logic [31:0] v);
    logic [31:0] r = w;
    for (int k = 0; k < nbytes(sz); k++) r[8*(first_b(sz, ea)+k) +: 8] = v[8*k +: 8];
    return r;
  endfunction
  function automatic logic [31:0] new_val(input logic [31:0] w, input logic [1:0] sz, input logic [15:0] ea, input logic [7:0] m);
    logic [31:0] s = get_lane(w, sz, ea) + {{24{m[7]}}, m};
    return put_lane(w, sz, ea, s);
  endfunction
  function automatic bit lane_zero(input logic [31:0] w, input logic [1:0] sz, input logic [15:0] ea, input logic [7:0] m);
    logic [31:0] s = get_lane(new_val(w, sz, ea, m), sz, ea);
    return s == 0;
  endfunction

  function automatic int tgt(input int lvl, input logic [15:0] ea, input bit me);
    logic [15:0] b = (me && lvl == 4) ? ea + MOFS : ea;
    return int'(b[9:2]);
  endfunction

  // set up location and counter for one level
  task automatic setup(input int lvl, input logic [1:0] sz, input logic [7:0] m,
                       input logic [15:0] ea, input logic [31:0] init, input bit me);
    mem[int'(LOCB[9:2]) + lvl] = {sz, 6'h2A, m, ea};
    mem[tgt(lvl, ea, me)] = init;
  endtask

  // wait for clr_arm; returns cycles counted from the request negedge
  task automatic wait_done(output int n, output logic [NLVL-1:0] ca, output logic ze, output logic [2:0] zl, output bit held);
    n = 0; held = 1'b1;
    forever begin
      @(negedge clk); n++;
      if (clr_arm != 0) break;
      if (n >= 2 && !prog_hold) held = 1'b0;
      if (n > 40) break;
    end
    ca = clr_arm; ze = zero_evt; zl = zero_lvl;
  endtask

  task automatic serve(input int lvl, input logic [1:0] sz, input logic [7:0] m,
                       input logic [15:0] ea, input logic [31:0] init, input bit me);
    int n; logic [NLVL-1:0] ca; logic ze; logic [2:0] zl; bit held;
    logic [31:0] exp; bit ez;
    setup(lvl, sz, m, ea, init, me);
    map_en = me;
    lvl_req = NLVL'(1) << lvl;
    @(negedge clk); lvl_req = '0;
    wait_done(n, ca, ze, zl, held);
    n++;
    exp = new_val(init, sz, ea, m);
    ez  = lane_zero(init, sz, ea, m) && CPM[lvl];
    chk(n == 7 && held, "R2 timing/hold", 32'(n), 32'd7);
    chk(ca == (NLVL'(1) << lvl), "R2 clr_arm", 32'(ca), 32'(NLVL'(1) << lvl));
    chk(mem[tgt(lvl, ea, me)] == exp, "R4 R3 write-back", mem[tgt(lvl, ea, me)], exp);
    chk(ze == ez && (!ez || zl == 3'(lvl)), "R6 zero event", {28'd0, zl, ze}, {28'd0, 3'(lvl), ez});
  endtask

  initial begin : wd
    #(PER * 150000);
    bad++; vecs++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int n; logic [NLVL-1:0] ca; logic ze; logic [2:0] zl; bit held;
    logic [31:0] w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 32'hA5A5_0000 + i;
    repeat (3) @(negedge clk);
    // R1
    chk(!mem_rd && !mem_wr && !prog_hold && clr_arm == 0 && !zero_evt, "R1 reset idle",
        {mem_rd, mem_wr, prog_hold, zero_evt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_rd && !mem_wr && !prog_hold, "R1 idle after reset", {mem_rd, mem_wr, prog_hold}, 0);

    // R4 byte wrap on a count-pulse level, neighbours kept; R6 zero fires
    serve(5, 2'b00, 8'h01, 16'h0202, 32'h11FF_2233, 1'b0);
    // R6 same wrap on non-count-pulse level: no event
    serve(1, 2'b00, 8'h01, 16'h0203, 32'hFF44_5566, 1'b0);
    // R4 word signed overflow wraps
    serve(6, 2'b10, 8'h01, 16'h0210, 32'h7FFF_FFFF, 1'b0);
    // R9-style size 11 treated as word (R3)
    serve(7, 2'b11, 8'hFF, 16'h0215, 32'h0000_0001, 1'b0);
    // R4 upper halfword, negative modifier
    serve(2, 2'b01, 8'h80, 16'h0222, 32'h0000_BEEF, 1'b0);
    // R5 mapped level with mapping on, physical word untouched
    w0 = mem[16'h0230 >> 2];
    serve(4, 2'b10, 8'h05, 16'h0230, 32'h0000_0100, 1'b1);
    chk(mem[16'h0230 >> 2] == w0, "R5 physical untouched", mem[16'h0230 >> 2], w0);
    // R5 other level ignores map_en
    serve(3, 2'b10, 8'h05, 16'h0234, 32'h0000_0100, 1'b1);
    map_en = 1'b0;

    // R7 two levels at once
    setup(2, 2'b10, 8'h01, 16'h0240, 32'h10, 1'b0);
    setup(5, 2'b10, 8'h01, 16'h0244, 32'h20, 1'b0);
    lvl_req = 8'b0010_0100;
    @(negedge clk); lvl_req = '0;
    wait_done(n, ca, ze, zl, held);
    chk(ca == 8'b0000_0100, "R7 lower level first", 32'(ca), 32'h4);
    wait_done(n, ca, ze, zl, held);
    chk(ca == 8'b0010_0000 && n == 7, "R7 second level next", 32'(ca), 32'h20);

    // R8 re-request during service
    setup(6, 2'b01, 8'h02, 16'h0250, 32'h0000_0010, 1'b0);
    lvl_req = 8'b0100_0000;
    @(negedge clk); lvl_req = '0;
    repeat (2) @(negedge clk);
    lvl_req = 8'b0100_0000;
    @(negedge clk); lvl_req = '0;
    wait_done(n, ca, ze, zl, held);
    chk(ca == 8'b0100_0000, "R8 first service", 32'(ca), 32'h40);
    wait_done(n, ca, ze, zl, held);
    chk(ca == 8'b0100_0000 && n == 7, "R8 pending served after re-arm", 32'(n), 32'd7);
    chk(mem[16'h0250 >> 2] == 32'h0000_0014, "R8 two increments", mem[16'h0250 >> 2], 32'h14);

    // random mix, about a quarter forced to a zero sum
    for (int it = 0; it < 60; it++) begin
      int lvl = int'($urandom_range(0, 7));
      logic [1:0] sz = 2'($urandom_range(0, 3));
      logic [7:0] m = 8'($urandom);
      logic [15:0] ea = 16'h0200 + 16'($urandom_range(0, 255));
      logic [31:0] init = $urandom;
      bit me = 1'($urandom);
      if ($urandom_range(0, 3) == 0) init = put_lane(init, sz, ea, -{{24{m[7]}}, m});
      serve(lvl, sz, m, ea, init, me);
    end
    map_en = 1'b0;

    @(negedge clk);
    chk(!prog_hold && !mem_rd && !mem_wr, "R2 returns idle", {prog_hold, mem_rd, mem_wr}, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule